// File: doc/BRIEF.md
# Serial Target Front End for a Timekeeping Register File

This block sits between a four-wire serial bus and the sixteen 8-bit registers of a real-time-clock core. The bus controller raises chip select, sends one command byte, and then streams data bytes in or out. The command byte names a register and one of four transfer kinds: single read, single write, burst read or burst write. During a burst the register address steps forward by one for every completed data byte and wraps from 15 to 0. A burst that starts at address 0 can therefore move all seven time registers (seconds, minutes, hours, weekday, day, month, year) inside one chip-select window. This keeps a time snapshot consistent.

Everything runs on the system clock. The serial clock, chip select and data input each pass through a two-flop synchronizer. Serial clock edges are found by comparing successive synchronized samples. The bus is used with the clock idling low, and the target samples on the falling edge and shifts on the rising edge. Towards the core the block gives a one-cycle read strobe or write strobe with an address and write data. It takes back the read data for the addressed register.

Top module: `rtcspi_target`

## Requirements
- R1: After synchronous reset, miso_o is 0 and neither reg_rd_stb_o nor reg_wr_stb_o is asserted.
- R2: The first byte after chip select rises is the command. Bits 7:4 are the register address. Bits 3:2 select the transfer: 2'b10 single write, 2'b11 single read, 2'b00 burst write, 2'b01 burst read. Bits 1:0 have no effect.
- R3: Chip select is active high and every byte is sent most significant bit first. The target samples mosi_i on falling serial clock edges and changes miso_o after rising edges. Each serial clock phase must last at least 4 system clock cycles.
- R4: A single write issues exactly one write strobe, to the command address, carrying the first data byte. Any later bytes in the same chip-select window produce no strobe.
- R5: A single read issues one read strobe for the command address once the command byte is complete. The register value is shifted out on miso_o during the first data byte. Any later bytes read as 0x00 and produce no strobe.
- R6: A burst write issues one write strobe per completed data byte, to consecutive addresses starting at the command address. Seven bytes from address 0 therefore fill registers 0 to 6 in order.
- R7: A burst read returns consecutive registers starting at the command address, one per data byte. Each completed data byte triggers a read strobe for the following address.
- R8: Burst addresses wrap from 15 to 0.
- R9: Any value shifted out from register 0 (seconds) has bit 7 forced to 0.
- R10: miso_o is 0 while chip select is inactive and throughout the command byte.
- R11: Dropping chip select ends the transaction. A partly received byte is discarded and causes no strobe, and the next transaction starts again with a command byte.
- R12: A strobe appears 4 system clock cycles after the system clock edge at which the serial clock input fell for the last bit of the byte. reg_rdata_i is taken at the clock edge that ends the read strobe cycle, for the address on reg_addr_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the controller, idle low |
| csel_i | input | 1 | Chip select, active high |
| mosi_i | input | 1 | Serial data from the controller |
| miso_o | output | 1 | Serial data to the controller |
| reg_rd_stb_o | output | 1 | One-cycle read request to the register core |
| reg_wr_stb_o | output | 1 | One-cycle write request to the register core |
| reg_addr_o | output | 4 | Register address for the current strobe |
| reg_wdata_o | output | 8 | Write data, valid with reg_wr_stb_o |
| reg_rdata_i | input | 8 | Read data for reg_addr_o from the register core |

## Verification
The serial clock falls on the falling edge of the system clock. The bench notes that cycle and expects any strobe exactly 4 rising edges later: two synchronizer stages, edge detection with the bit register, and the strobe register. It samples the strobes 1 time unit after each rising edge. miso_o is updated 3 system cycles after a serial rising edge, so the bench reads it just before the next serial falling edge, 4 cycles after the rise, as a real controller would. The bench models the register core and the expected transfers with queues and checks the strobes against them every cycle. After chip select has been low for 4 cycles it expects miso_o to be 0 on every cycle.

// File: rtl/rtcspi_pkg.sv
`timescale 1ns/1ps
package rtcspi_pkg;

    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 8;
    localparam int BIT_CNT_W = $clog2(DATA_W);
    localparam int SPARE_W   = DATA_W - ADDR_W - 2;

    localparam logic [ADDR_W-1:0] SEC_ADDR = '0;

    // transfer kind held in command bits 3:2
    typedef enum logic [1:0] {
        MD_BURST_WR  = 2'b00,
        MD_BURST_RD  = 2'b01,
        MD_SINGLE_WR = 2'b10,
        MD_SINGLE_RD = 2'b11
    } xfer_mode_e;

    typedef struct packed {
        logic [ADDR_W-1:0]  addr;
        xfer_mode_e         mode;
        logic [SPARE_W-1:0] spare;
    } cmd_t;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_DATA,
        PH_DONE
    } phase_e;

    function automatic logic mode_is_read(xfer_mode_e m);
        return m[0];
    endfunction

    function automatic logic mode_is_burst(xfer_mode_e m);
        return ~m[1];
    endfunction

    // seconds register never shows its top bit on the bus
    function automatic logic [DATA_W-1:0] mask_rdata(logic [ADDR_W-1:0] a,
                                                     logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] r;
        r = d;
        if (a == SEC_ADDR) r[DATA_W-1] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/rtcspi_sync.sv
`timescale 1ns/1ps
module rtcspi_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[0] <= '0;
                else     stage_q[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/rtcspi_shifter.sv
`timescale 1ns/1ps
module rtcspi_shifter
    import rtcspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_data,
    output logic              byte_done_o,
    output logic [DATA_W-1:0] byte_o,
    output logic              miso_o,
    output logic              tx_msb_o
);
    logic                 sclk_prev;
    logic                 sclk_rise;
    logic                 sclk_fall;
    logic [BIT_CNT_W-1:0] bit_cnt;
    logic [DATA_W-1:0]    rx_q;
    logic [DATA_W-1:0]    tx_q;
    logic                 miso_q;
    logic                 done_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_prev <= 1'b0;
        else     sclk_prev <= sclk_s;
    end

    assign sclk_rise = sclk_s & ~sclk_prev;
    assign sclk_fall = ~sclk_s & sclk_prev;

    always_ff @(posedge clk) begin
        if (rst || !cs_act) begin
            bit_cnt <= '0;
            rx_q    <= '0;
            tx_q    <= '0;
            miso_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load_en) begin
                tx_q <= load_data;
            end else if (sclk_rise) begin
                miso_q <= tx_q[DATA_W-1];
                tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
            end
            if (sclk_fall) begin
                rx_q <= {rx_q[DATA_W-2:0], mosi_s};
                if (bit_cnt == BIT_CNT_W'(DATA_W - 1)) begin
                    bit_cnt <= '0;
                    done_q  <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    assign byte_done_o = done_q;
    assign byte_o      = rx_q;
    assign miso_o      = miso_q;
    assign tx_msb_o    = tx_q[DATA_W-1];
endmodule

// File: rtl/rtcspi_ctrl.sv
`timescale 1ns/1ps
module rtcspi_ctrl
    import rtcspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act,
    input  logic              byte_done,
    input  logic [DATA_W-1:0] rx_byte,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    output logic              rd_stb_o,
    output logic              wr_stb_o
);
    cmd_t              cmd_w;
    logic              unused_spare;
    phase_e            phase_q;
    xfer_mode_e        mode_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              rd_q;
    logic              wr_q;

    assign cmd_w        = cmd_t'(rx_byte);
    assign unused_spare = ^cmd_w.spare;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_CMD;
            mode_q  <= MD_BURST_WR;
            addr_q  <= '0;
            wdata_q <= '0;
            rd_q    <= 1'b0;
            wr_q    <= 1'b0;
        end else if (!cs_act) begin
            phase_q <= PH_CMD;
            rd_q    <= 1'b0;
            wr_q    <= 1'b0;
        end else begin
            rd_q <= 1'b0;
            wr_q <= 1'b0;
            // step past a register once its burst write has gone out
            if (wr_q && mode_is_burst(mode_q)) addr_q <= addr_q + 1'b1;
            if (byte_done) begin
                unique case (phase_q)
                    PH_CMD: begin
                        addr_q  <= cmd_w.addr;
                        mode_q  <= cmd_w.mode;
                        phase_q <= PH_DATA;
                        rd_q    <= mode_is_read(cmd_w.mode);
                    end
                    PH_DATA: begin
                        if (!mode_is_read(mode_q)) begin
                            wr_q    <= 1'b1;
                            wdata_q <= rx_byte;
                            if (!mode_is_burst(mode_q)) phase_q <= PH_DONE;
                        end else if (mode_is_burst(mode_q)) begin
                            addr_q <= addr_q + 1'b1;
                            rd_q   <= 1'b1;
                        end else begin
                            phase_q <= PH_DONE;
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    assign reg_addr_o  = addr_q;
    assign reg_wdata_o = wdata_q;
    assign rd_stb_o    = rd_q;
    assign wr_stb_o    = wr_q;
endmodule

// File: rtl/rtcspi_target.sv
`timescale 1ns/1ps
module rtcspi_target
    import rtcspi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_i,
    input  logic              csel_i,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic              reg_rd_stb_o,
    output logic              reg_wr_stb_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    input  logic [DATA_W-1:0] reg_rdata_i
);
    localparam int N_SYNC = 3;

    logic [N_SYNC-1:0] pins_s;
    logic              sclk_s;
    logic              cs_s;
    logic              mosi_s;
    logic              byte_done;
    logic [DATA_W-1:0] rx_byte;
    logic [DATA_W-1:0] load_data;
    logic              tx_msb;

    rtcspi_sync #(
        .WIDTH  (N_SYNC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({sclk_i, csel_i, mosi_i}),
        .dout (pins_s)
    );

    assign sclk_s = pins_s[2];
    assign cs_s   = pins_s[1];
    assign mosi_s = pins_s[0];

    assign load_data = mask_rdata(reg_addr_o, reg_rdata_i);

    rtcspi_shifter u_shift (
        .clk         (clk),
        .rst         (rst),
        .cs_act      (cs_s),
        .sclk_s      (sclk_s),
        .mosi_s      (mosi_s),
        .load_en     (reg_rd_stb_o),
        .load_data   (load_data),
        .byte_done_o (byte_done),
        .byte_o      (rx_byte),
        .miso_o      (miso_o),
        .tx_msb_o    (tx_msb)
    );

    rtcspi_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cs_act      (cs_s),
        .byte_done   (byte_done),
        .rx_byte     (rx_byte),
        .reg_addr_o  (reg_addr_o),
        .reg_wdata_o (reg_wdata_o),
        .rd_stb_o    (reg_rd_stb_o),
        .wr_stb_o    (reg_wr_stb_o)
    );
endmodule

// File: rtl/rtcspi_target_chk.sv
`timescale 1ns/1ps
module rtcspi_target_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_act,
    input logic       byte_done,
    input logic       tx_msb,
    input logic       miso,
    input logic       rd_stb,
    input logic       wr_stb,
    input logic [3:0] addr
);
    AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(rd_stb && wr_stb)); // R2

    AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb); // R6

    AST_RD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> !rd_stb); // R7

    AST_MISO_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> (miso == 1'b0)); // R10

    AST_NO_STB_IDLE: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> (!rd_stb && !wr_stb)); // R11

    AST_SEC_TOP_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && addr == 4'd0) |=> !tx_msb); // R9

    AST_STB_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
        (rd_stb || wr_stb) |-> $past(byte_done)); // R12
endmodule

bind rtcspi_target rtcspi_target_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_act    (cs_s),
    .byte_done (byte_done),
    .tx_msb    (tx_msb),
    .miso      (miso_o),
    .rd_stb    (reg_rd_stb_o),
    .wr_stb    (reg_wr_stb_o),
    .addr      (reg_addr_o)
);

// File: tb/rtcspi_target_tb_top.sv
`timescale 1ns/1ps
module rtcspi_target_tb_top;
    localparam int HALF = 4;

    logic       clk  = 1'b0;
    logic       rst  = 1'b1;
    logic       sclk = 1'b0;
    logic       cs   = 1'b0;
    logic       mosi = 1'b0;
    logic       miso;
    logic       rd_stb;
    logic       wr_stb;
    logic [3:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;

    logic [7:0] stub_regs [16];
    logic [7:0] exp_regs  [16];

    int checks    = 0;
    int errors    = 0;
    int cyc       = 0;
    int last_fall = 0;
    int cs_low    = 0;
    bit done      = 0;

    int q_wa [$];
    int q_wd [$];
    int q_ra [$];

    always #2 clk = ~clk;

    rtcspi_target dut_i (
        .clk          (clk),
        .rst          (rst),
        .sclk_i       (sclk),
        .csel_i       (cs),
        .mosi_i       (mosi),
        .miso_o       (miso),
        .reg_rd_stb_o (rd_stb),
        .reg_wr_stb_o (wr_stb),
        .reg_addr_o   (addr),
        .reg_wdata_o  (wdata),
        .reg_rdata_i  (rdata)
    );

    // behavioural register core
    assign rdata = stub_regs[addr];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) stub_regs[i] <= 8'h00;
        end else if (wr_stb) begin
            stub_regs[addr] <= wdata;
        end
    end

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int expv(input int a);
        return (a == 0) ? (exp_regs[a] & 8'h7F) : int'(exp_regs[a]);
    endfunction

    // per-cycle comparison against the expected strobe queues
    always @(posedge clk) begin
        #1;
        if (!rst) begin
            if (wr_stb) begin
                if (q_wa.size() == 0) begin
                    chk("R4/R6 unexpected write strobe addr", int'(addr), -1);
                end else begin
                    chk("R6 write address", int'(addr), q_wa.pop_front());
                    chk("R6 write data", int'(wdata), q_wd.pop_front());
                end
                chk("R12 write strobe latency", cyc - last_fall, 4);
            end
            if (rd_stb) begin
                if (q_ra.size() == 0) begin
                    chk("R5/R7 unexpected read strobe addr", int'(addr), -1);
                end else begin
                    chk("R7 read address", int'(addr), q_ra.pop_front());
                end
                chk("R12 read strobe latency", cyc - last_fall, 4);
            end
            if (!cs) cs_low++;
            else     cs_low = 0;
            if (cs_low >= 4) chk("R10 miso idle", int'(miso), 0);
        end
    end

    task automatic cs_on();
        @(negedge clk);
        cs = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic cs_off(input string tag);
        repeat (HALF) @(negedge clk);
        cs   = 1'b0;
        sclk = 1'b0;
        repeat (10) @(negedge clk);
        chk(tag, q_wa.size() + q_ra.size(), 0);
    endtask

    task automatic spi_bit(input logic b, output logic got);
        sclk = 1'b1;
        mosi = b;
        repeat (HALF) @(negedge clk);
        got       = miso;
        sclk      = 1'b0;
        last_fall = cyc;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        logic g;
        rx = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            spi_bit(tx[i], g);
            rx = {rx[6:0], g};
        end
    endtask

    task automatic send_cmd(input logic [7:0] cmd);
        logic [7:0] r;
        spi_byte(cmd, r);
        chk("R10 miso during command", int'(r), 0);
    endtask

    task automatic burst_write(input logic [3:0] a, input int n, input logic [7:0] seed);
        logic [7:0] r;
        cs_on();
        send_cmd({a, 4'b0000});
        for (int i = 0; i < n; i++) begin
            logic [7:0] v;
            int ad;
            v  = seed + 8'(i * 17);
            ad = (int'(a) + i) % 16;
            q_wa.push_back(ad);
            q_wd.push_back(int'(v));
            exp_regs[ad] = v;
            spi_byte(v, r);
        end
        cs_off("R6/R8 burst write strobes all seen");
    endtask

    task automatic burst_read(input logic [3:0] a, input int n);
        logic [7:0] r;
        cs_on();
        q_ra.push_back(int'(a));
        send_cmd({a, 4'b0100});
        for (int i = 0; i < n; i++) begin
            int ad;
            ad = (int'(a) + i) % 16;
            q_ra.push_back((ad + 1) % 16);
            spi_byte(8'h00, r);
            chk("R3/R7/R8/R9 burst read byte", int'(r), expv(ad));
        end
        cs_off("R7 burst read strobes all seen");
    endtask

    task automatic single_write(input logic [3:0] a, input logic [7:0] v, input bit extra);
        logic [7:0] r;
        cs_on();
        send_cmd({a, 4'b1000});
        q_wa.push_back(int'(a));
        q_wd.push_back(int'(v));
        exp_regs[a] = v;
        spi_byte(v, r);
        if (extra) spi_byte(8'hA5, r);
        cs_off("R4 single write strobes");
    endtask

    task automatic single_read(input logic [3:0] a, input logic [1:0] low, input bit extra);
        logic [7:0] r;
        cs_on();
        q_ra.push_back(int'(a));
        send_cmd({a, 2'b11, low});
        spi_byte(8'h00, r);
        chk("R2/R5 single read data", int'(r), expv(int'(a)));
        if (extra) begin
            spi_byte(8'h00, r);
            chk("R5 single read trailing byte", int'(r), 0);
        end
        cs_off("R5 single read strobes");
    endtask

    initial begin
        for (int i = 0; i < 16; i++) exp_regs[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset miso", int'(miso), 0);
        chk("R1 reset read strobe", int'(rd_stb), 0);
        chk("R1 reset write strobe", int'(wr_stb), 0);

        // R6: seven time registers from address 0, seconds written with bit 7 set
        burst_write(4'd0, 7, 8'hD9);
        // R7/R9: read them back in order, seconds top bit masked
        burst_read(4'd0, 7);
        // R4: single write with an ignored trailing byte
        single_write(4'd14, 8'h20, 1'b1);
        // R5: single read with a trailing byte that reads as zero
        single_read(4'd14, 2'b00, 1'b1);
        // R8: wrap on write and on read
        burst_write(4'd15, 2, 8'h3C);
        burst_read(4'd14, 4);

        // R11: partial byte dropped by chip select
        begin
            logic [7:0] r;
            logic       g;
            cs_on();
            send_cmd({4'd3, 4'b0000});
            q_wa.push_back(3);
            q_wd.push_back(8'h5A);
            exp_regs[3] = 8'h5A;
            spi_byte(8'h5A, r);
            for (int i = 0; i < 3; i++) spi_bit(1'b1, g);
            cs_off("R11 partial byte gives no strobe");
        end
        // R11/R2: fresh command after abort, low command bits ignored
        single_read(4'd4, 2'b11, 1'b0);
        single_read(4'd3, 2'b01, 1'b0);
        // R2: single write to control register 15 then read back
        single_write(4'd15, 8'h81, 1'b0);
        single_read(4'd15, 2'b10, 1'b1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule